// File: doc/BRIEF.md
# Parallel-Port Service Interrupt Generator

This block produces the single interrupt request of an extended-capabilities parallel port. It watches the port's FIFO fill and free-space counts, the terminal-count strobe of the DMA engine, and two peripheral status pins: a fault line and an acknowledge line, both active low. It reduces all of them to one registered request pulse. Software sets five control inputs. One mask bit blocks the service sources, which are DMA completion and the FIFO thresholds. One bit selects DMA or programmed-I/O service. One bit gives the transfer direction. The last two bits gate the fault and acknowledge sources.

For programmed I/O the block compares the FIFO against a threshold that depends on direction. Toward the peripheral it compares free space with the write threshold. From the peripheral it compares the stored bytes with the read threshold. It raises a request on the cycle where that condition becomes true. That cycle also covers the case where the mask is released while the condition already holds. The fault and acknowledge pins are asynchronous, so each passes through its own synchronizer before its edge is taken. The FIFO, the DMA engine and the register decode belong to other blocks.

Top module: `ppirq_gen`

## Requirements
- R1: During reset and afterwards, `irq` stays 0 until a source event occurs. Reset treats both status pins as having been high and the fault-disable input as having been low.
- R2: While `svc_mask` is 1, neither `dma_tc` nor a FIFO threshold condition raises `irq`.
- R3: With `svc_mask`=0 and `dma_mode`=1, each cycle in which `dma_tc` is 1 gives `irq`=1 in the following cycle. FIFO thresholds are ignored in this mode.
- R4: With `svc_mask`=0, `dma_mode`=0 and `dir_rev`=0, `irq` pulses in the cycle after `fifo_free` >= `wr_thresh` becomes true. This includes a threshold of 0 and a threshold equal to the FIFO size.
- R5: With `svc_mask`=0, `dma_mode`=0 and `dir_rev`=1, `irq` pulses in the cycle after `fifo_used` >= `rd_thresh` becomes true. This includes a threshold equal to the FIFO size.
- R6: A threshold condition that stays true raises exactly one pulse. It does not retrigger until the condition has gone false and become true again.
- R7: If the threshold condition already holds when `svc_mask` changes from 1 to 0, `irq` pulses in the next cycle.
- R8: With `err_dis`=0, a high-to-low change of `periph_err_n` raises `irq` SYNC_STAGES clock edges after the first edge that samples the new level. A low-to-high change raises nothing.
- R9: A change of `err_dis` from 1 to 0 while the synchronized `periph_err_n` is low raises `irq` in the next cycle. The same change with the pin high raises nothing.
- R10: With `ack_en`=1, a low-to-high change of `periph_ack_n` raises `irq` with the R8 latency. A high-to-low change, or any change while `ack_en`=0, raises nothing.
- R11: `irq` is registered. Sources that fire in the same cycle produce a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_mask | input | 1 | 1 blocks the DMA and threshold sources |
| dma_mode | input | 1 | 1 selects DMA service, 0 selects programmed I/O |
| dir_rev | input | 1 | 0 is host-to-peripheral, 1 is peripheral-to-host |
| err_dis | input | 1 | 1 disables the fault source |
| ack_en | input | 1 | 1 enables the acknowledge source |
| wr_thresh | input | CNT_W | Free-space threshold for the write direction |
| rd_thresh | input | CNT_W | Fill threshold for the read direction |
| fifo_used | input | CNT_W | Bytes held in the FIFO |
| fifo_free | input | CNT_W | Free byte slots in the FIFO |
| dma_tc | input | 1 | DMA terminal-count strobe |
| periph_err_n | input | 1 | Asynchronous peripheral fault pin, active low |
| periph_ack_n | input | 1 | Asynchronous peripheral acknowledge pin |
| irq | output | 1 | Registered interrupt pulse |

## Verification
The bench builds the block with CNT_W=5 and SYNC_STAGES=3. CNT_W=5 makes a full 16-byte FIFO representable, so the thresholds of 0 and of 16 and the counts at both ends can be driven. SYNC_STAGES=3 goes one stage beyond the default. This shows that the pin-event latency follows the parameter and is not fixed at two. It also lets a synchronized acknowledge edge be lined up in the same cycle as a DMA strobe, which exercises the merging of sources.

// File: rtl/ppirq_pkg.sv
package ppirq_pkg;

   typedef struct packed {
      logic tc;
      logic thr;
      logic flt;
      logic ack;
   } irq_src_t;

   function automatic logic irq_any(input irq_src_t s);
      return s.tc | s.thr | s.flt | s.ack;
   endfunction

endpackage

// File: rtl/ppirq_sync.sv
module ppirq_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   initial begin
      assert (STAGES >= 2) else $error("ppirq_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ppirq_edge.sv
module ppirq_edge #(
   parameter bit   RISING = 1'b1,
   parameter logic INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic evt
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= INIT;
      else        prev <= d;
   end

   if (RISING) begin : g_rise
      assign evt = d & ~prev;
   end else begin : g_fall
      assign evt = ~d & prev;
   end

   // R11: an edge event can never repeat on the next cycle
   p_edge_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
endmodule

// File: rtl/ppirq_thresh.sv
module ppirq_thresh #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             svc_mask,
   input  logic             dma_mode,
   input  logic             dir_rev,
   input  logic [CNT_W-1:0] wr_thresh,
   input  logic [CNT_W-1:0] rd_thresh,
   input  logic [CNT_W-1:0] fifo_used,
   input  logic [CNT_W-1:0] fifo_free,
   output logic             evt
);
   logic wr_hit, rd_hit, cond, cond_q;

   assign wr_hit = (fifo_free >= wr_thresh);
   assign rd_hit = (fifo_used >= rd_thresh);
   assign cond   = ~svc_mask & ~dma_mode & (dir_rev ? rd_hit : wr_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= 1'b0;
      else        cond_q <= cond;
   end

   assign evt = cond & ~cond_q;

   // R6: a held condition fires once
   p_thr_no_retrig_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);
   // R2: masked service never produces a threshold event
   p_thr_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      svc_mask |-> !evt);
endmodule

// File: rtl/ppirq_gen.sv
module ppirq_gen
   import ppirq_pkg::*;
#(
   parameter int CNT_W       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             svc_mask,
   input  logic             dma_mode,
   input  logic             dir_rev,
   input  logic             err_dis,
   input  logic             ack_en,
   input  logic [CNT_W-1:0] wr_thresh,
   input  logic [CNT_W-1:0] rd_thresh,
   input  logic [CNT_W-1:0] fifo_used,
   input  logic [CNT_W-1:0] fifo_free,
   input  logic             dma_tc,
   input  logic             periph_err_n,
   input  logic             periph_ack_n,
   output logic             irq
);
   initial begin
      assert (CNT_W >= 1)       else $error("ppirq_gen: CNT_W must be positive");
      assert (SYNC_STAGES >= 2) else $error("ppirq_gen: SYNC_STAGES must be at least 2");
   end

   logic     flt_s, ack_s;
   logic     flt_fall, ack_rise, dis_fall, thr_evt;
   irq_src_t src;

   ppirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_flt (
      .clk(clk), .rst_n(rst_n), .d(periph_err_n), .q(flt_s));
   ppirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ack (
      .clk(clk), .rst_n(rst_n), .d(periph_ack_n), .q(ack_s));

   ppirq_edge #(.RISING(1'b0), .INIT(1'b1)) u_edge_flt (
      .clk(clk), .rst_n(rst_n), .d(flt_s), .evt(flt_fall));
   ppirq_edge #(.RISING(1'b1), .INIT(1'b1)) u_edge_ack (
      .clk(clk), .rst_n(rst_n), .d(ack_s), .evt(ack_rise));
   ppirq_edge #(.RISING(1'b0), .INIT(1'b0)) u_edge_dis (
      .clk(clk), .rst_n(rst_n), .d(err_dis), .evt(dis_fall));

   ppirq_thresh #(.CNT_W(CNT_W)) u_thresh (
      .clk(clk), .rst_n(rst_n), .svc_mask(svc_mask), .dma_mode(dma_mode),
      .dir_rev(dir_rev), .wr_thresh(wr_thresh), .rd_thresh(rd_thresh),
      .fifo_used(fifo_used), .fifo_free(fifo_free), .evt(thr_evt));

   always_comb begin
      src.tc  = ~svc_mask & dma_mode & dma_tc;
      src.thr = thr_evt;
      src.flt = ~err_dis & (flt_fall | (dis_fall & ~flt_s));
      src.ack = ack_en & ack_rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= irq_any(src);
   end

   // R3: DMA completion while unmasked is always reported
   p_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!svc_mask && dma_mode && dma_tc) |=> irq);
   // R2: masked, with no pin source active, gives no request
   p_mask_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_mask && !flt_fall && !dis_fall && !ack_rise) |=> !irq);
   // R8: enabled fault edge is reported
   p_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_dis && flt_fall) |=> irq);
   // R9: enabling the fault source with the fault present reports it
   p_fault_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_fall && !flt_s) |=> irq);
   // R10: enabled acknowledge rise is reported
   p_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && ack_rise) |=> irq);
endmodule

// File: tb/ppirq_gen_bench.sv
`timescale 1ns/1ps
module ppirq_gen_bench;
   localparam int CNT_W = 5;
   localparam int SYNC  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic svc_mask = 1'b1, dma_mode = 1'b0, dir_rev = 1'b0, err_dis = 1'b1, ack_en = 1'b0;
   logic [CNT_W-1:0] wr_thresh = '0, rd_thresh = '0, fifo_used = '0, fifo_free = '0;
   logic dma_tc = 1'b0, periph_err_n = 1'b1, periph_ack_n = 1'b1;
   logic irq;

   always #2 clk = ~clk;

   ppirq_gen #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) u_ppirq_gen (
      .clk(clk), .rst_n(rst_n), .svc_mask(svc_mask), .dma_mode(dma_mode),
      .dir_rev(dir_rev), .err_dis(err_dis), .ack_en(ack_en),
      .wr_thresh(wr_thresh), .rd_thresh(rd_thresh), .fifo_used(fifo_used),
      .fifo_free(fifo_free), .dma_tc(dma_tc), .periph_err_n(periph_err_n),
      .periph_ack_n(periph_ack_n), .irq(irq));

   // behavioural reference model
   bit fq[$];
   bit aq[$];
   bit m_cprev, m_fprev, m_aprev, m_dprev, m_cond, m_ev, m_fs, m_as;
   bit exp_irq;

   always @(posedge clk) begin
      if (!rst_n) begin
         fq = {}; aq = {};
         for (int i = 0; i < SYNC; i++) begin fq.push_back(1'b1); aq.push_back(1'b1); end
         m_cprev = 0; m_fprev = 1; m_aprev = 1; m_dprev = 0; exp_irq = 0;
      end else begin
         m_fs = fq[$];
         m_as = aq[$];
         m_cond = !svc_mask && !dma_mode &&
                  (dir_rev ? (int'(fifo_used) >= int'(rd_thresh))
                           : (int'(fifo_free) >= int'(wr_thresh)));
         m_ev = (!svc_mask && dma_mode && dma_tc)
             || (m_cond && !m_cprev)
             || (!err_dis && m_fprev && !m_fs)
             || (m_dprev && !err_dis && !m_fs)
             || (ack_en && !m_aprev && m_as);
         exp_irq = m_ev;
         m_cprev = m_cond; m_fprev = m_fs; m_aprev = m_as; m_dprev = err_dis;
         fq.push_front(periph_err_n); void'(fq.pop_back());
         aq.push_front(periph_ack_n); void'(aq.pop_back());
      end
   end

   int    total = 0, fails = 0, pulses = 0;
   string cur = "R1";
   bit    done = 0;

   task automatic step();
      @(negedge clk);
      total++;
      if (irq !== exp_irq) begin
         fails++;
         $display("FAIL %s: cycle compare irq=%0b expected %0b at %0t", cur, irq, exp_irq, $time);
      end
      if (irq === 1'b1) pulses++;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic expect_count(input string req, input int want);
      total++;
      if (pulses != want) begin
         fails++;
         $display("FAIL %s: pulse count %0d expected %0d", req, pulses, want);
      end
      pulses = 0;
   endtask

   initial begin
      // R1: reset behaviour
      cur = "R1"; run(4); rst_n = 1'b1; pulses = 0; run(6);
      expect_count("R1", 0);

      // R2: mask blocks DMA and threshold
      cur = "R2"; dma_mode = 1; dma_tc = 1; run(1); dma_tc = 0; dma_mode = 0;
      fifo_free = 16; wr_thresh = 8; run(6);
      expect_count("R2", 0);

      // R7: unmask with condition already true
      cur = "R7"; svc_mask = 0; run(8);
      expect_count("R7", 1);

      // R6: held condition does not retrigger
      cur = "R6"; run(10);
      expect_count("R6", 0);

      // R4: write-direction threshold crossing
      cur = "R4"; fifo_free = 3; run(3); fifo_free = 7; run(3); fifo_free = 8; run(4);
      fifo_free = 16; run(3);
      expect_count("R4", 1);
      svc_mask = 1; run(2); wr_thresh = 0; fifo_free = 0; svc_mask = 0; run(3);
      expect_count("R4", 1);

      // R5: read-direction threshold crossing, including the full-FIFO threshold
      cur = "R5"; dir_rev = 1; fifo_used = 0; rd_thresh = 4; run(3);
      fifo_used = 3; run(2); fifo_used = 4; run(3); fifo_used = 16; run(2);
      rd_thresh = 16; fifo_used = 15; run(2); fifo_used = 16; run(3);
      expect_count("R5", 2);

      // R3: DMA terminal count, single and back to back
      cur = "R3"; dma_mode = 1; run(2);
      dma_tc = 1; run(1); dma_tc = 0; run(3);
      dma_tc = 1; run(2); dma_tc = 0; run(3);
      expect_count("R3", 3);
      cur = "R2"; svc_mask = 1; dma_tc = 1; run(1); dma_tc = 0; run(2);
      expect_count("R2", 0);

      // R8: fault pin edges
      cur = "R8"; err_dis = 0; periph_err_n = 0; run(6); periph_err_n = 1; run(6);
      expect_count("R8", 1);

      // R9: enabling the fault source
      cur = "R9"; err_dis = 1; periph_err_n = 0; run(6); err_dis = 0; run(4);
      err_dis = 1; run(2); periph_err_n = 1; run(6); err_dis = 0; run(3);
      expect_count("R9", 1);

      // R10: acknowledge edges
      cur = "R10"; ack_en = 1; periph_ack_n = 0; run(6); periph_ack_n = 1; run(6);
      expect_count("R10", 1);
      ack_en = 0; periph_ack_n = 0; run(5); periph_ack_n = 1; run(6);
      expect_count("R10", 0);

      // R11: acknowledge and DMA strobe in the same cycle merge to one pulse
      cur = "R11"; ack_en = 1; svc_mask = 0; dma_mode = 1; periph_ack_n = 0; run(6);
      pulses = 0;
      periph_ack_n = 1; run(SYNC); dma_tc = 1; run(1); dma_tc = 0; run(4);
      expect_count("R11", 1);

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++; total++;
         $display("FAIL watchdog: run incomplete actual=hung expected=done");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end
endmodule